// File: doc/BRIEF.md
# Factory-Restore Service Request Controller

This block holds a keyed service-request register and a sequencer. Together they check a pending factory-restore request and then carry it out. Software writes a 32-bit word to the register. The top byte is a key. The low 24 bits are either a status marker or an offset that points to a request record in system SRAM.

When a write is accepted, the block first issues a system reset pulse. It then examines the offset. If the offset is a real pointer, the block checks its alignment and its range. It then fetches a four-word record through a word-addressed read port and compares the record against a fixed signature.

If every check holds, six erase or restore steps run one after another, each through its own start/done handshake. At the end, the offset field is cleared to the success code and a second reset pulse goes out. If any check fails, the offset field is overwritten with the failure code and nothing is erased. The erase engines themselves sit outside this block.

Top module: `restore_req_ctrl`

## Requirements
- R1: A write is accepted only when `reg_wr_data[31:24]` equals 0xCA and the sequencer is idle. On acceptance, `reg_wr_data[23:0]` is stored in the offset field. `reg_rd_data` always reads as {7'b0, busy in bit 24, offset in bits 23:0}.
- R2: A write whose key byte differs from 0xCA leaves the offset field unchanged and starts no activity.
- R3: While busy reads 1, every write is ignored, including one that carries the correct key.
- R4: In the cycle after an accepted write, `sys_reset` is high for exactly one cycle and busy reads 1. The offset is examined only in the cycle after that.
- R5: An accepted offset of 0x000000 or 0xFFFFFF is a marker, not a pointer. No memory read and no step follows, busy drops two cycles after acceptance, and the offset field keeps the written value.
- R6: A pointer is valid only when its bits 1:0 are zero and 0x2000_0000 plus the offset lies in 0x2000_4000..0x2003_FFF0 inclusive. An invalid pointer causes no read, no step and no second reset. The offset field becomes 0xFFFFFF and busy drops in the next cycle.
- R7: For a valid pointer, four reads are issued in order at word addresses (offset >> 2) + 0..3. Each `mem_rd_en` lasts one cycle, data is taken one cycle later, and reads are spaced two cycles apart.
- R8: The record words must equal 0xFEED0001, 0x02010100, 0x0D080503 and 0x59372215, in that order. The first mismatch stops the fetch, starts no step, and writes 0xFFFFFF to the offset field.
- R9: Steps run in this order: `step_start` bit 0 (retention RAM clear), 1 (SRAM clear), 2 (flash protection open), 3 (EEPROM erase), 4 (flash mass erase), 5 (boot configuration write).
  - Each start is a one-cycle pulse.
  - A step advances only on its own `step_done` bit, seen in a cycle after its start.
  - Done bits of other steps, and a done bit in the start cycle itself, are ignored.
- R10: `cfg_wdata` reads 0xFFFFFFFF while step 2 is active, 0xFFFFFFFE while step 5 is active, and 0 otherwise.
- R11: After the done of step 5, `sys_reset` pulses for one cycle. Then the offset field reads 0x000000 and busy reads 0.
- R12: After reset, the offset field is 0x000000, busy is 0, and `sys_reset`, `mem_rd_en`, `step_start` and `cfg_wdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Request register write strobe |
| reg_wr_data | input | 32 | Key byte and 24-bit offset |
| reg_rd_data | output | 32 | Busy flag and offset field |
| mem_rd_en | output | 1 | SRAM read strobe |
| mem_rd_addr | output | MEM_AW | SRAM word address |
| mem_rd_data | input | 32 | SRAM read data, one cycle after the strobe |
| step_start | output | 6 | One-hot start pulse per step |
| step_done | input | 6 | Completion flag per step |
| cfg_wdata | output | 32 | Value written by the configuration steps |
| sys_reset | output | 1 | One-cycle system reset pulse |

## Verification
The bound checker checks the following on every cycle:
- an accepted write is followed by a reset pulse with busy set;
- reset pulses, read strobes and step starts never last longer than one cycle;
- at most one start is high at a time;
- the offset field holds still unless a write is accepted or a result is posted;
- each posted result leaves the expected code with busy clear.

Some behaviours can only be shown by the bench's scenarios against its cycle model:
- the pointer range boundaries and misalignment;
- the exact read addresses and the order of the signature words;
- rejection at the first wrong word;
- the ordering of the six steps when done bits arrive early or on the wrong step;
- writes landing mid-sequence.

// File: rtl/restore_pkg.sv
package restore_pkg;
  localparam int KEY_W   = 8;
  localparam int OFF_W   = 24;
  localparam int WORD_W  = 32;
  localparam int STEP_N  = 6;
  localparam int SIG_LEN = 4;
  localparam int STEP_W  = $clog2(STEP_N);
  localparam int IDX_W   = $clog2(SIG_LEN);

  localparam logic [KEY_W-1:0]  WR_KEY      = 8'hCA;
  localparam logic [OFF_W-1:0]  OFF_OK      = 24'h000000;
  localparam logic [OFF_W-1:0]  OFF_BAD     = 24'hFFFFFF;
  localparam logic [WORD_W-1:0] SRAM_BASE   = 32'h2000_0000;
  localparam logic [WORD_W-1:0] PTR_FLOOR   = 32'h2000_4000;
  localparam logic [WORD_W-1:0] PTR_CEIL    = 32'h2003_FFF0;
  localparam int                STEP_PROT   = 2;
  localparam int                STEP_BOOT   = 5;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_RST, SQ_CHK, SQ_FETCH, SQ_CMP, SQ_GO, SQ_WAIT, SQ_FIN
  } seq_state_t;

  // Expected record word for a given fetch index
  function automatic logic [WORD_W-1:0] sig_word(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    return 32'hFEED_0001;
      2'd1:    return 32'h0201_0100;
      2'd2:    return 32'h0D08_0503;
      default: return 32'h5937_2215;
    endcase
  endfunction

  // Data word presented to the configuration steps
  function automatic logic [WORD_W-1:0] step_value(input logic [STEP_W-1:0] k);
    if (k == STEP_W'(STEP_PROT)) return 32'hFFFF_FFFF;
    if (k == STEP_W'(STEP_BOOT)) return 32'hFFFF_FFFE;
    return '0;
  endfunction

  function automatic logic is_marker(input logic [OFF_W-1:0] off);
    return (off == OFF_OK) || (off == OFF_BAD);
  endfunction

  // Alignment and range test on the full system address
  function automatic logic ptr_ok(input logic [OFF_W-1:0] off);
    logic [WORD_W-1:0] addr;
    addr = SRAM_BASE + {{(WORD_W-OFF_W){1'b0}}, off};
    return (off[1:0] == 2'b00) && (addr >= PTR_FLOOR) && (addr <= PTR_CEIL);
  endfunction
endpackage

// File: rtl/restore_req_reg.sv
module restore_req_reg
  import restore_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              busy,
  input  logic              post_ok,
  input  logic              post_fail,
  output logic              accept,
  output logic [OFF_W-1:0]  offset
);
  logic key_hit;

  assign key_hit = (wr_data[WORD_W-1 -: KEY_W] == WR_KEY);
  assign accept  = wr_en && key_hit && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         offset <= OFF_OK;
    else if (accept)    offset <= wr_data[OFF_W-1:0];
    else if (post_fail) offset <= OFF_BAD;
    else if (post_ok)   offset <= OFF_OK;
  end
endmodule

// File: rtl/restore_ptr_check.sv
module restore_ptr_check
  import restore_pkg::*;
#(
  parameter int MEM_AW = 16
) (
  input  logic [OFF_W-1:0]  offset,
  output logic              marker,
  output logic              valid,
  output logic [MEM_AW-1:0] word_base
);
  localparam int HI_BIT = MEM_AW + 1;

  assign marker    = is_marker(offset);
  assign valid     = ptr_ok(offset);
  assign word_base = offset[HI_BIT:2];
endmodule

// File: rtl/restore_seq.sv
module restore_seq
  import restore_pkg::*;
#(
  parameter int MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              marker,
  input  logic              valid,
  input  logic [MEM_AW-1:0] word_base,
  input  logic [WORD_W-1:0] mem_rd_data,
  input  logic [STEP_N-1:0] step_done,
  output logic              busy,
  output logic              post_ok,
  output logic              post_fail,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  output logic [STEP_N-1:0] step_start,
  output logic [WORD_W-1:0] cfg_wdata,
  output logic              sys_reset
);
  seq_state_t        state, state_nx;
  logic [IDX_W-1:0]  idx, idx_nx;
  logic [STEP_W-1:0] step, step_nx;
  logic              word_bad;
  logic              this_done;
  logic              last_step;

  assign word_bad  = (mem_rd_data != sig_word(idx));
  assign this_done = step_done[step];
  assign last_step = (step == STEP_W'(STEP_N - 1));

  always_comb begin
    state_nx  = state;
    idx_nx    = idx;
    step_nx   = step;
    post_ok   = 1'b0;
    post_fail = 1'b0;
    case (state)
      SQ_IDLE:  if (accept) state_nx = SQ_RST;
      SQ_RST:   state_nx = SQ_CHK;
      SQ_CHK: begin
        if (marker) state_nx = SQ_IDLE;
        else if (!valid) begin
          post_fail = 1'b1;
          state_nx  = SQ_IDLE;
        end else begin
          idx_nx   = '0;
          state_nx = SQ_FETCH;
        end
      end
      SQ_FETCH: state_nx = SQ_CMP;
      SQ_CMP: begin
        if (word_bad) begin
          post_fail = 1'b1;
          state_nx  = SQ_IDLE;
        end else if (idx == IDX_W'(SIG_LEN - 1)) begin
          step_nx  = '0;
          state_nx = SQ_GO;
        end else begin
          idx_nx   = idx + 1'b1;
          state_nx = SQ_FETCH;
        end
      end
      SQ_GO:    state_nx = SQ_WAIT;
      SQ_WAIT: begin
        if (this_done) begin
          if (last_step) state_nx = SQ_FIN;
          else begin
            step_nx  = step + 1'b1;
            state_nx = SQ_GO;
          end
        end
      end
      SQ_FIN: begin
        post_ok  = 1'b1;
        state_nx = SQ_IDLE;
      end
      default:  state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      idx   <= '0;
      step  <= '0;
    end else begin
      state <= state_nx;
      idx   <= idx_nx;
      step  <= step_nx;
    end
  end

  assign busy        = (state != SQ_IDLE);
  assign sys_reset   = (state == SQ_RST) || (state == SQ_FIN);
  assign mem_rd_en   = (state == SQ_FETCH);
  assign mem_rd_addr = word_base + {{(MEM_AW-IDX_W){1'b0}}, idx};
  assign cfg_wdata   = ((state == SQ_GO) || (state == SQ_WAIT)) ? step_value(step) : '0;

  for (genvar g = 0; g < STEP_N; g++) begin : g_start
    assign step_start[g] = (state == SQ_GO) && (step == STEP_W'(g));
  end
endmodule

// File: rtl/restore_req_ctrl.sv
module restore_req_ctrl
  import restore_pkg::*;
#(
  parameter int MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wr_data,
  output logic [31:0]       reg_rd_data,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic [5:0]        step_start,
  input  logic [5:0]        step_done,
  output logic [31:0]       cfg_wdata,
  output logic              sys_reset
);
  localparam int PAD_W = WORD_W - OFF_W - 1;

  logic              accept_evt;
  logic              ok_evt;
  logic              fail_evt;
  logic              busy;
  logic              ptr_marker;
  logic              ptr_valid;
  logic [OFF_W-1:0]  offset_q;
  logic [MEM_AW-1:0] word_base;

  restore_req_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_data   (reg_wr_data),
    .busy      (busy),
    .post_ok   (ok_evt),
    .post_fail (fail_evt),
    .accept    (accept_evt),
    .offset    (offset_q)
  );

  restore_ptr_check #(.MEM_AW(MEM_AW)) u_ptr (
    .offset    (offset_q),
    .marker    (ptr_marker),
    .valid     (ptr_valid),
    .word_base (word_base)
  );

  restore_seq #(.MEM_AW(MEM_AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept_evt),
    .marker      (ptr_marker),
    .valid       (ptr_valid),
    .word_base   (word_base),
    .mem_rd_data (mem_rd_data),
    .step_done   (step_done),
    .busy        (busy),
    .post_ok     (ok_evt),
    .post_fail   (fail_evt),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .step_start  (step_start),
    .cfg_wdata   (cfg_wdata),
    .sys_reset   (sys_reset)
  );

  assign reg_rd_data = {{PAD_W{1'b0}}, busy, offset_q};
endmodule

// File: rtl/restore_req_ctrl_chk.sv
module restore_req_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [31:0] reg_wr_data,
  input logic        accept_evt,
  input logic        ok_evt,
  input logic        fail_evt,
  input logic        busy,
  input logic [23:0] offset_q,
  input logic        mem_rd_en,
  input logic [5:0]  step_start,
  input logic [31:0] cfg_wdata,
  input logic        sys_reset
);
  // R4
  accept_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (sys_reset && busy));

  // R11
  reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |=> !sys_reset);

  // R9
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_start));

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_start != 6'd0) |=> (step_start == 6'd0));

  // R7
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ok_evt && !fail_evt) |=> $stable(offset_q));

  // R2
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr_en && (reg_wr_data[31:24] != 8'hCA)) |=> ($stable(offset_q) && !busy));

  // R6
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> ((offset_q == 24'hFFFFFF) && !busy));

  // R11
  ok_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_evt |=> ((offset_q == 24'h000000) && !busy));

  // R10
  cfg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wdata != 32'd0) |-> busy);
endmodule

bind restore_req_ctrl restore_req_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .accept_evt  (accept_evt),
  .ok_evt      (ok_evt),
  .fail_evt    (fail_evt),
  .busy        (busy),
  .offset_q    (offset_q),
  .mem_rd_en   (mem_rd_en),
  .step_start  (step_start),
  .cfg_wdata   (cfg_wdata),
  .sys_reset   (sys_reset)
);

// File: tb/restore_req_ctrl_test.sv
`timescale 1ns/1ps
module restore_req_ctrl_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [31:0]   reg_wr_data = '0;
  logic [31:0]   reg_rd_data;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [31:0]   mem_rd_data = '0;
  logic [5:0]    step_start;
  logic [5:0]    step_done = '0;
  logic [31:0]   cfg_wdata;
  logic          sys_reset;

  restore_req_ctrl #(.MEM_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .step_start(step_start), .step_done(step_done),
    .cfg_wdata(cfg_wdata), .sys_reset(sys_reset)
  );

  always #10 clk = ~clk;

  // Behavioural SRAM with one-cycle read latency
  logic [31:0] sram [int];
  function automatic logic [31:0] peek(int a);
    return sram.exists(a) ? sram[a] : 32'h0;
  endfunction
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= peek(int'(mem_rd_addr));

  typedef struct packed {
    bit        busy;
    bit        rst;
    bit        rd;
    bit [31:0] addr;
    bit [5:0]  start;
    bit [31:0] cfg;
    bit [23:0] off;
    bit [5:0]  done;
  } exp_t;

  exp_t      q[$];
  bit [23:0] m_off = 24'h0;
  int        vectors = 0;
  int        fails = 0;
  int        cycles = 0;
  string     scen = "R12";
  bit [31:0] sig [4] = '{32'hFEED0001, 32'h02010100, 32'h0D080503, 32'h59372215};

  task automatic push(bit b, bit r, bit rd, bit [31:0] a, bit [5:0] st,
                      bit [31:0] c, bit [23:0] o, bit [5:0] d);
    exp_t e;
    e.busy = b; e.rst = r; e.rd = rd; e.addr = a; e.start = st;
    e.cfg = c; e.off = o; e.done = d;
    q.push_back(e);
  endtask

  // Expected trace of an accepted request, one entry per cycle
  task automatic plan(bit [23:0] off, int lat, bit early, bit stray);
    int base;
    push(1, 1, 0, 0, 0, 0, off, 0);
    push(1, 0, 0, 0, 0, 0, off, 0);
    if (off == 24'h000000 || off == 24'hFFFFFF) begin m_off = off; return; end
    if (off % 4 != 0 || off < 24'h004000 || off > 24'h03FFF0) begin
      m_off = 24'hFFFFFF; return;
    end
    base = int'(off) / 4;
    for (int i = 0; i < 4; i++) begin
      push(1, 0, 1, base + i, 0, 0, off, 0);
      push(1, 0, 0, 0, 0, 0, off, 0);
      if (peek(base + i) != sig[i]) begin m_off = 24'hFFFFFF; return; end
    end
    for (int k = 0; k < 6; k++) begin
      bit [31:0] c;
      bit [5:0]  own;
      c   = (k == 2) ? 32'hFFFFFFFF : (k == 5) ? 32'hFFFFFFFE : 32'h0;
      own = 6'b1 << k;
      push(1, 0, 0, 0, own, c, off, early ? own : 6'b0);
      for (int j = 1; j <= lat; j++) begin
        bit [5:0] d;
        d = (j == lat) ? own : 6'b0;
        if (stray && j == 1 && lat > 1) d = d | (6'b1 << ((k + 1) % 6));
        push(1, 0, 0, 0, 0, c, off, d);
      end
    end
    push(1, 1, 0, 0, 0, 0, off, 0);
    m_off = 24'h000000;
  endtask

  task automatic chk(string fld, string req, bit [31:0] got, bit [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (scenario %s) %s: got %h expected %h", req, scen, fld, got, exp);
    end
  endtask

  // One clock: compare this cycle's outputs, then drive its inputs
  task automatic tick(bit we, bit [31:0] wd, int lat = 2, bit early = 0, bit stray = 0);
    exp_t e;
    @(negedge clk);
    if (q.size() != 0) e = q.pop_front();
    else begin e = '0; e.off = m_off; end
    chk("reg_rd_data", "R1", reg_rd_data, {7'b0, e.busy, e.off});
    chk("sys_reset", "R4", {31'b0, sys_reset}, {31'b0, e.rst});
    chk("mem_rd_en", "R7", {31'b0, mem_rd_en}, {31'b0, e.rd});
    if (e.rd) chk("mem_rd_addr", "R7", {16'b0, mem_rd_addr}, e.addr);
    chk("step_start", "R9", {26'b0, step_start}, {26'b0, e.start});
    chk("cfg_wdata", "R10", cfg_wdata, e.cfg);
    step_done   = e.done;
    reg_wr_en   = we;
    reg_wr_data = wd;
    if (!e.busy && we && wd[31:24] == 8'hCA) plan(wd[23:0], lat, early, stray);
  endtask

  task automatic drain();
    while (q.size() != 0) tick(0, 0);
    tick(0, 0);
  endtask

  task automatic request(bit [31:0] wd, int lat = 2, bit early = 0, bit stray = 0);
    tick(1, wd, lat, early, stray);
    drain();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      sram[32'h1000 + i] = sig[i];    // record at offset 0x4000
      sram[32'hFFFC + i] = sig[i];    // record at offset 0x3FFF0
      sram[32'h2000 + i] = sig[i];    // offset 0x8000, third word corrupted
      sram[32'h2400 + i] = sig[i];    // offset 0x9000, first word corrupted
    end
    sram[32'h2002] = 32'h0D080504;
    sram[32'h2400] = 32'hFEED0002;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    scen = "R12";  repeat (3) tick(0, 0);
    scen = "R2";   tick(1, 32'h35004000); tick(1, 32'hCB03FFF0); repeat (3) tick(0, 0);
    scen = "R5";   request(32'hCA000000); request(32'hCAFFFFFF); request(32'hCA000000);
    scen = "R6";   request(32'hCA004002); request(32'hCA003FFC); request(32'hCA03FFF4);
    scen = "R8";   request(32'hCA008000); request(32'hCA009000);
    scen = "R3";
    tick(1, 32'hCA004000, 3, 1, 1);
    tick(1, 32'hCA009000);
    repeat (12) tick(0, 0);
    tick(1, 32'hCA000000);
    repeat (10) tick(0, 0);
    tick(1, 32'hCA004002);
    drain();
    scen = "R11";  request(32'hCA03FFF0, 1);
    scen = "R7";   request(32'hCA004000, 4, 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule